// File: doc/BRIEF.md
# Chunked DDC EDID Read Engine

This block is a register-mapped I2C master that fetches a display's EDID over the DDC pins. Software sets a byte count and the EDID command in the control register, then sets the enable bit. The engine then addresses the display's EEPROM at 7-bit address 0x50 and sets the word offset to zero. It issues a repeated start and streams the requested bytes into a 64-byte read window. That window is seen as sixteen 32-bit words.

A transfer longer than the window is delivered in 64-byte pieces. When the window fills and bytes remain, the engine flags buffer-full. It then parks the bus with SCL held low until software writes the continue bit. When the last byte arrives the engine sends NAK and then STOP, and flags done. A missing acknowledge during addressing flags an error and aborts with STOP. Each flag can raise a level interrupt under a per-bit enable mask. Software clears a flag by writing 1 to it.

Top module: `ddc_chunk_reader`

## Requirements
- R1: After reset both bus lines are released, `irq` is low, and the control (0x40), interrupt-enable (0x44) and status (0x48) registers read as zero. A register read returns data on `bus_rdata` in the cycle after `bus_rd`.
- R2: A transfer starts only on a control write with enable (bit 0) set, command field [3:2] equal to 3 and a non-zero byte count in bits [20 +: LEN_W]. Any other command value, or a zero count, causes no bus activity and sets no status bit.
- R3: Each transfer shows exactly two START conditions and one STOP on the bus. It writes address 0x50 with offset 0x00, then reads from 0x50. The bytes come back in target order starting at offset 0.
- R4: Byte n of the current piece sits in the window word at byte address 4*(n/4), in bits [8*(n%4) +: 8] (little-endian). The window spans addresses 0x00 to 0x3C.
- R5: When the 64th byte of a piece lands and bytes remain, status bit 3 (buffer-full) sets. SCL is then held low and no byte is lost until a control write with bit 1 set resumes the transfer.
- R6: After the last byte the master sends NAK and then STOP, and sets status bit 2 (done). Both lines are released. Buffer-full is not raised for the final piece, even when it is exactly 64 bytes.
- R7: A missing ACK to an address or offset byte sets status bit 4 (error), ends with STOP and both lines released, and never sets done.
- R8: After done or error the engine ignores new start requests until a control write clears enable. After that write a new transfer can begin.
- R9: Writing 1 to a status bit clears it. If the engine sets a bit in the same cycle that software clears it, the set wins.
- R10: `irq` is registered and equals the OR over bits of (status AND enable), one cycle late. An enable value of zero keeps `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register or window word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| scl_in | input | 1 | Sampled level of the clock line |
| sda_in | input | 1 | Sampled level of the data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| irq | output | 1 | Level interrupt |

## Verification
Two things can land in the same clock edge: the engine raising buffer-full and software writing 1 to clear that same bit. The bench provokes this by writing the clear to the status register every cycle while a piece is being received. The arriving 64th byte must therefore coincide with a clear. The collision is judged by a one-cycle `irq` pulse, which only a winning set can produce. Afterwards the bench checks that buffer-full reads clear and that SCL is still held low.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WR, OP_RD} op_t;

  localparam logic [7:0] REG_CTRL = 8'h40;
  localparam logic [7:0] REG_IEN  = 8'h44;
  localparam logic [7:0] REG_STAT = 8'h48;

  localparam int BIT_DONE = 2;
  localparam int BIT_FULL = 3;
  localparam int BIT_ERR  = 4;
  localparam int LEN_LSB  = 20;

  localparam logic [1:0] CMD_EDID  = 2'd3;
  localparam logic [6:0] EDID_DEV  = 7'h50;
  localparam logic [4:0] STAT_MASK = 5'b11100;
  localparam logic [4:0] IEN_MASK  = 5'b11101;
endpackage

// File: rtl/ddc_i2c_phy.sv
module ddc_i2c_phy
  import ddc_pkg::*;
#(
  parameter int QDIV = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       op_valid,
  input  op_t        op,
  input  logic [7:0] op_byte,
  input  logic       op_nak,
  output logic       op_ready,
  output logic       op_done,
  output logic [7:0] rx_byte,
  output logic       rx_ack,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_STOP, PH_BYTE} ph_t;

  ph_t          st;
  logic [CW-1:0] dcnt;
  logic [1:0]   phase;
  logic [3:0]   bitn;
  logic [7:0]   sh;
  logic         is_rd, nak;

  wire tick = (dcnt == CW'(QDIV - 1));
  wire adv  = tick && (st != PH_IDLE) && !(phase == 2'd2 && !scl_in);

  assign op_ready = (st == PH_IDLE);
  assign rx_byte  = sh;

  always_ff @(posedge clk) begin
    if (rst) dcnt <= '0;
    else     dcnt <= tick ? '0 : dcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= PH_IDLE; phase <= '0; bitn <= '0; sh <= '0;
      is_rd <= 1'b0; nak <= 1'b0; op_done <= 1'b0; rx_ack <= 1'b0;
      scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (op_valid && op_ready) begin
        st    <= (op == OP_START) ? PH_START : (op == OP_STOP) ? PH_STOP : PH_BYTE;
        phase <= '0;
        bitn  <= '0;
        sh    <= op_byte;
        is_rd <= (op == OP_RD);
        nak   <= op_nak;
      end else if (adv) begin
        phase <= phase + 2'd1;
        case (st)
          PH_START: begin
            case (phase)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: begin scl_low <= 1'b1; st <= PH_IDLE; op_done <= 1'b1; end
            endcase
          end
          PH_STOP: begin
            case (phase)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: begin st <= PH_IDLE; op_done <= 1'b1; end
            endcase
          end
          PH_BYTE: begin
            case (phase)
              2'd0: sda_low <= (bitn == 4'd8) ? (is_rd && !nak) : (!is_rd && !sh[7]);
              2'd1: scl_low <= 1'b0;
              2'd2: begin
                if (bitn == 4'd8) rx_ack <= !sda_in;
                else              sh <= {sh[6:0], sda_in};
              end
              default: begin
                scl_low <= 1'b1;
                if (bitn == 4'd8) begin st <= PH_IDLE; op_done <= 1'b1; end
                else bitn <= bitn + 4'd1;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  // R3: inside a byte, data only moves while the clock line is held low
  p_sda_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (st == PH_BYTE && !scl_low && $past(!scl_low)) |-> $stable(sda_low));

  // R6: a finished STOP leaves both lines released
  p_stop_frees_r6: assert property (@(posedge clk) disable iff (rst)
    (st == PH_STOP && adv && phase == 2'd3) |=> (!scl_low && !sda_low));
endmodule

// File: rtl/ddc_window.sv
module ddc_window #(
  parameter int WORDS = 16,
  localparam int WA_W = $clog2(WORDS),
  localparam int BA_W = WA_W + 2
) (
  input  logic            clk,
  input  logic            we,
  input  logic [BA_W-1:0] waddr,
  input  logic [7:0]      wbyte,
  input  logic [WA_W-1:0] raddr,
  output logic [31:0]     rword
);
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we && waddr[1:0] == 2'(l)) mem[waddr[BA_W-1:2]] <= wbyte;
      q <= mem[raddr];
    end
    assign rword[8*l +: 8] = q;
  end
endmodule

// File: rtl/ddc_chunk_reader.sv
module ddc_chunk_reader
  import ddc_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SCL_HZ    = 100_000,
  parameter int LEN_W     = 12,
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              irq
);
  localparam int QDIV  = CLK_HZ / (4 * SCL_HZ);
  localparam int WORDS = WIN_BYTES / 4;
  localparam int IDX_W = $clog2(WIN_BYTES);
  localparam int WA_W  = $clog2(WORDS);

  typedef enum logic [3:0] {S_IDLE, S_ST1, S_AW, S_OFF, S_ST2, S_AR, S_RD,
                            S_STALL, S_STOP, S_HOLD} st_t;

  st_t              st;
  logic             en, pend, abort;
  logic [1:0]       cmd;
  logic [LEN_W-1:0] len, rcnt;
  logic [IDX_W-1:0] widx;
  logic [4:0]       ien, stat;
  logic             op_valid, op_nak, op_ready, phy_done, rx_ack;
  op_t              op;
  logic [7:0]       op_byte, rx_byte;
  logic [31:0]      rword, rreg, ctrl_rd;
  logic             rsel_win;

  wire wr_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  wire wr_ien  = bus_wr && (bus_addr == ADDR_W'(REG_IEN));
  wire wr_stat = bus_wr && (bus_addr == ADDR_W'(REG_STAT));

  wire last    = (rcnt == len - 1'b1);
  wire byte_in = phy_done && (st == S_RD);
  wire ev_full = byte_in && !last && (widx == '1);
  wire ev_done = phy_done && (st == S_STOP) && !abort;
  wire ev_err  = phy_done && (st == S_AW || st == S_OFF || st == S_AR) && !rx_ack;

  always_comb begin
    op_valid = 1'b0; op = OP_START; op_byte = 8'h00; op_nak = 1'b0;
    if (!pend) begin
      case (st)
        S_ST1, S_ST2: op_valid = 1'b1;
        S_AW:   begin op_valid = 1'b1; op = OP_WR; op_byte = {EDID_DEV, 1'b0}; end
        S_OFF:  begin op_valid = 1'b1; op = OP_WR; op_byte = 8'h00; end
        S_AR:   begin op_valid = 1'b1; op = OP_WR; op_byte = {EDID_DEV, 1'b1}; end
        S_RD:   begin op_valid = 1'b1; op = OP_RD; op_nak = last; end
        S_STOP: begin op_valid = 1'b1; op = OP_STOP; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; en <= 1'b0; cmd <= '0; len <= '0; rcnt <= '0;
      widx <= '0; pend <= 1'b0; abort <= 1'b0;
    end else begin
      if (op_valid && op_ready) pend <= 1'b1;
      if (phy_done)             pend <= 1'b0;
      case (st)
        S_IDLE: if (wr_ctrl) begin
          en  <= bus_wdata[0];
          cmd <= bus_wdata[3:2];
          len <= bus_wdata[LEN_LSB +: LEN_W];
          if (bus_wdata[0] && bus_wdata[3:2] == CMD_EDID && bus_wdata[LEN_LSB +: LEN_W] != '0) begin
            st <= S_ST1; rcnt <= '0; widx <= '0; abort <= 1'b0;
          end
        end
        S_ST1: if (phy_done) st <= S_AW;
        S_AW:  if (phy_done) begin st <= rx_ack ? S_OFF : S_STOP; abort <= !rx_ack; end
        S_OFF: if (phy_done) begin st <= rx_ack ? S_ST2 : S_STOP; abort <= !rx_ack; end
        S_ST2: if (phy_done) st <= S_AR;
        S_AR:  if (phy_done) begin st <= rx_ack ? S_RD : S_STOP; abort <= !rx_ack; end
        S_RD:  if (phy_done) begin
          rcnt <= rcnt + 1'b1;
          widx <= widx + 1'b1;
          if (last)            st <= S_STOP;
          else if (widx == '1) st <= S_STALL;
        end
        S_STALL: if (wr_ctrl && bus_wdata[1]) st <= S_RD;
        S_STOP:  if (phy_done) st <= S_HOLD;
        S_HOLD:  if (wr_ctrl && !bus_wdata[0]) begin en <= 1'b0; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0; ien <= '0; irq <= 1'b0;
    end else begin
      stat <= ((stat & ~(wr_stat ? bus_wdata[4:0] : 5'b0)) |
               {ev_err, ev_full, ev_done, 2'b00}) & STAT_MASK;
      if (wr_ien) ien <= bus_wdata[4:0] & IEN_MASK;
      irq <= |(stat & ien);
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[LEN_LSB +: LEN_W] = len;
    ctrl_rd[3:2] = cmd;
    ctrl_rd[0]   = en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rreg <= '0; rsel_win <= 1'b0;
    end else if (bus_rd) begin
      rsel_win <= (bus_addr < ADDR_W'(WIN_BYTES));
      case (bus_addr)
        ADDR_W'(REG_CTRL): rreg <= ctrl_rd;
        ADDR_W'(REG_IEN):  rreg <= {27'b0, ien};
        ADDR_W'(REG_STAT): rreg <= {27'b0, stat};
        default:           rreg <= '0;
      endcase
    end
  end

  assign bus_rdata = rsel_win ? rword : rreg;

  ddc_window #(.WORDS(WORDS)) i_window (
    .clk(clk), .we(byte_in), .waddr(widx), .wbyte(rx_byte),
    .raddr(bus_addr[2 +: WA_W]), .rword(rword)
  );

  ddc_i2c_phy #(.QDIV(QDIV)) i_phy (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .op_byte(op_byte),
    .op_nak(op_nak), .op_ready(op_ready), .op_done(phy_done), .rx_byte(rx_byte),
    .rx_ack(rx_ack), .scl_in(scl_in), .sda_in(sda_in),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  // R5: a parked transfer keeps the clock line low
  p_stall_holds_scl_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_STALL) |-> scl_drive_low);

  // R5: buffer-full only appears together with the parked state
  p_full_means_stall_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[BIT_FULL]) |-> (st == S_STALL));

  // R6: done is flagged only once every requested byte has been counted
  p_done_after_all_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[BIT_DONE]) |-> (rcnt == len));

  // R7: an aborted transfer has received no data bytes
  p_abort_no_data_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && abort) |-> (rcnt == '0));

  // R10: a zero enable mask keeps the interrupt low
  p_mask_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq);
endmodule

// File: tb/test_ddc_chunk_reader.sv
`timescale 1ns/1ps
module test_ddc_chunk_reader;
  localparam logic [7:0] A_CTRL = 8'h40, A_IEN = 8'h44, A_STAT = 8'h48;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic scl_drive_low, sda_drive_low, irq;
  logic tgt_low, tgt_present;
  wire scl_w = !scl_drive_low;
  wire sda_w = !(sda_drive_low || tgt_low);

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddc_chunk_reader #(.CLK_HZ(200_000_000), .SCL_HZ(25_000_000)) i_ddc_chunk_reader (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_in(scl_w), .sda_in(sda_w),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .irq(irq)
  );

  function automatic logic [7:0] tgt_byte(input logic [7:0] a);
    return (a * 8'd29) ^ 8'h5A;
  endfunction

  // EEPROM-like target at 0x50
  logic [1:0] tmode; logic [3:0] bitc; logic [7:0] tsh, tout, tptr, ofs_seen;
  logic tack, trw, pscl, psda, last_mack;
  int starts, stops;
  always @(negedge clk) begin
    if (rst) begin
      tmode <= 0; bitc <= 0; tsh <= 0; tout <= 0; tptr <= 0; ofs_seen <= 8'hFF;
      tack <= 0; trw <= 0; tgt_low <= 0; pscl <= 1; psda <= 1; last_mack <= 1;
      starts <= 0; stops <= 0;
    end else begin
      if (pscl && scl_w && psda && !sda_w) begin
        tmode <= 1; bitc <= 0; tack <= 0; tgt_low <= 0; starts <= starts + 1;
      end else if (pscl && scl_w && !psda && sda_w) begin
        tmode <= 0; tgt_low <= 0; stops <= stops + 1;
      end else if (!pscl && scl_w) begin
        if ((tmode == 1 || tmode == 2) && !tack && bitc < 8) begin
          tsh <= {tsh[6:0], sda_w}; bitc <= bitc + 1;
        end else if (tmode == 3 && bitc < 8) bitc <= bitc + 1;
        else if (tmode == 3) begin
          last_mack <= !sda_w;
          if (!sda_w) begin tptr <= tptr + 1; tout <= tgt_byte(tptr + 8'd1); bitc <= 0; end
          else tmode <= 0;
        end
      end else if (pscl && !scl_w) begin
        if ((tmode == 1 || tmode == 2) && bitc == 8 && !tack) begin
          if (tmode == 2) begin tptr <= tsh; ofs_seen <= tsh; tgt_low <= 1; tack <= 1; end
          else if (tsh[7:1] == 7'h50 && tgt_present) begin trw <= tsh[0]; tgt_low <= 1; tack <= 1; end
          else tmode <= 0;
        end else if (tack) begin
          tack <= 0; bitc <= 0;
          if (tmode == 1 && trw) begin
            tmode <= 3; tout <= tgt_byte(tptr); tgt_low <= !tgt_byte(tptr)[7];
          end else begin tgt_low <= 0; tmode <= 2; end
        end else if (tmode == 3) tgt_low <= (bitc < 8) ? !tout[3'(7 - bitc)] : 1'b0;
      end
      pscl <= scl_w; psda <= sda_w;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s: actual %h expected %h", req, act, exp); end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic lines_idle(input int n, input string req);
    bit ok = 1;
    repeat (n) begin @(negedge clk); if (scl_drive_low || sda_drive_low) ok = 0; end
    check(ok, req, {scl_drive_low, sda_drive_low}, 0);
  endtask

  task automatic wait_flags(output logic [31:0] s);
    forever begin
      bus_read(A_STAT, s);
      if ((s & 32'h1C) != 0) break;
      repeat (20) @(negedge clk);
    end
  endtask

  task automatic read_piece(input int cnt, input int base);
    for (int w = 0; w < (cnt + 3) / 4; w++) begin
      logic [31:0] d, e;
      bus_read(8'(w * 4), d);
      e = d;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < cnt) e[8*b +: 8] = tgt_byte(8'(base + w * 4 + b));
      check(d == e, "R4/R5 window data", d, e);
    end
  endtask

  task automatic run_read(input int len, input logic [4:0] ien_v);
    int got = 0, st0, sp0;
    logic [31:0] s;
    bit fin = 0;
    bus_write(A_IEN, {27'b0, ien_v});
    st0 = starts; sp0 = stops;
    bus_write(A_CTRL, (32'(len) << 20) | 32'hD);
    while (!fin) begin
      wait_flags(s);
      check(irq == |(s[4:0] & ien_v), "R10 irq level", irq, |(s[4:0] & ien_v));
      if (s[2]) begin
        check(s[3] == 0 && s[4] == 0, "R6 done alone", s, 32'h4);
        read_piece(len - got, got);
        check(starts - st0 == 2 && stops - sp0 == 1, "R3 start/stop count",
              starts - st0, 2);
        check(ofs_seen == 8'h00, "R3 offset byte", ofs_seen, 0);
        check(last_mack == 1'b0, "R6 last byte NAK", last_mack, 0);
        lines_idle(40, "R6 lines released");
        bus_write(A_CTRL, 32'h0050000D);
        lines_idle(120, "R8 restart ignored");
        bus_write(A_STAT, 32'h4);
        bus_read(A_STAT, s);
        check(s == 0, "R9 clear done", s, 0);
        bus_write(A_CTRL, 0);
        fin = 1;
      end else begin
        check(s[3] == 1 && s[4] == 0, "R5 full flag", s, 32'h8);
        read_piece(64, got);
        got += 64;
        bus_write(A_STAT, 32'h8);
        bus_write(A_CTRL, (32'(len) << 20) | 32'hF);
      end
    end
  endtask

  initial begin
    wait (cyc >= 190000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int seed, len;
    bit seen, held;
    tgt_present = 1;
    repeat (5) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(irq == 0, "R1 irq", irq, 0);
    check(!scl_drive_low && !sda_drive_low, "R1 lines", {scl_drive_low, sda_drive_low}, 0);
    bus_read(A_CTRL, d); check(d == 0, "R1 ctrl", d, 0);
    bus_read(A_IEN, d);  check(d == 0, "R1 ien", d, 0);
    bus_read(A_STAT, d); check(d == 0, "R1 stat", d, 0);

    // R2: other commands and zero count start nothing
    bus_write(A_CTRL, 32'h00800009);
    lines_idle(200, "R2 non-EDID command");
    bus_write(A_CTRL, 32'h0000000D);
    lines_idle(200, "R2 zero count");
    bus_read(A_STAT, d); check(d == 0, "R2 no status", d, 0);
    bus_write(A_CTRL, 0);

    // directed: short, exact window, multi-piece
    run_read(5, 5'b00100);
    run_read(64, 5'b11100);
    run_read(150, 5'b01000);

    // R10: masked flag, then enable
    bus_write(A_IEN, 0);
    bus_write(A_CTRL, (32'd3 << 20) | 32'hD);
    wait_flags(d);
    check(irq == 0, "R10 masked", irq, 0);
    bus_write(A_IEN, 32'h4);
    @(negedge clk);
    check(irq == 1, "R10 unmasked", irq, 1);
    bus_write(A_STAT, 32'h4);
    bus_write(A_CTRL, 0);
    @(negedge clk);
    check(irq == 0, "R9 clear drops irq", irq, 0);

    // R7: absent target
    tgt_present = 0;
    bus_write(A_IEN, 32'h10);
    bus_write(A_CTRL, (32'd8 << 20) | 32'hD);
    wait_flags(d);
    check(d == 32'h10, "R7 error only", d, 32'h10);
    check(irq == 1, "R7 irq", irq, 1);
    lines_idle(60, "R7 lines released");
    bus_read(A_STAT, d); check(d == 32'h10, "R7 no done later", d, 32'h10);
    bus_write(A_STAT, 32'h10);
    bus_write(A_CTRL, 0);
    tgt_present = 1;

    // R9 collision: clear full every cycle while first piece arrives
    bus_write(A_IEN, 32'h8);
    bus_write(A_CTRL, (32'd100 << 20) | 32'hD);
    seen = 0;
    @(negedge clk); bus_wr = 1; bus_addr = A_STAT; bus_wdata = 32'h8;
    for (int n = 0; n < 20000 && !seen; n++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    @(negedge clk); bus_wr = 0;
    check(seen, "R9 set wins over clear", seen, 1);
    bus_read(A_STAT, d); check(d == 0, "R9 cleared after", d, 0);
    held = 1;
    repeat (300) begin @(negedge clk); if (!scl_drive_low) held = 0; end
    check(held, "R5 SCL held in stall", held, 1);
    bus_write(A_IEN, 0);
    bus_write(A_CTRL, (32'd100 << 20) | 32'hF);
    wait_flags(d);
    check(d == 32'h4, "R5 resumed to done", d, 32'h4);
    read_piece(36, 64);
    bus_write(A_STAT, 32'h4);
    bus_write(A_CTRL, 0);

    // constrained random lengths and masks
    seed = $urandom(32'h5EED);
    for (int k = 0; k < 5; k++) begin
      len = 1 + $urandom_range(139, 0);
      run_read(len, 5'($urandom_range(31, 0)) & 5'b11100);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule